// File: doc/BRIEF.md
# Aligning Sticky Adder-Subtractor with Normalizer

This block is the addition stage of a fused multiply-add datapath. It takes a product significand that already carries guard, round and sticky bits (27 bits, leading one at bit 26) and a plain 24-bit addend significand. Each comes with its own sign and signed exponent. The block first gives the addend three empty low bits. It then lines up the two exponents by shifting the smaller operand right while keeping a sticky bit. It adds the magnitudes when the signs match and subtracts the smaller from the larger when they differ. A subtraction result is shifted left so that bit 26 is set again.

The result is an unrounded 27-bit significand, ready for a separate rounding and packing stage. It comes with a sign, an exponent and a flag for an exact-zero difference. The sign of that zero follows the round-toward-minus input. All arithmetic is combinational. The result is captured in output registers on the edge where `in_valid` is high and is presented one cycle later with `out_valid`.

A two-state controller paces the output. The states are `ST_IDLE` (no result this cycle) and `ST_EMIT` (a fresh result is on the outputs). There are two transitions, and they are taken from either state. *accept* moves to `ST_EMIT` when `in_valid` is high. *drain* moves to `ST_IDLE` when `in_valid` is low.

Top module: `fma_align_norm`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. After reset, `out_valid`, `res_sign`, `res_exp`, `res_sig` and `res_zero` are all 0.
- R2: The addend significand enters the sum as `add_sig` shifted left by 3, so bits 2:0 of the addend operand are zero before alignment.
- R3: The operand with the smaller exponent is shifted right by the exponent difference. Bit 0 of the shifted value is ORed with every bit shifted out. The working exponent is the larger of the two.
- R4: A right shift of 27 or more positions gives a value whose only possible one is bit 0, and that bit is 1 exactly when the operand was nonzero.
- R5: When the signs are equal, the aligned significands are added and `res_sign` is the common sign. If the sum carries into bit 27, the sum is shifted right one place, the bit shifted out is ORed into bit 0, and the exponent is raised by 1.
- R6: When the signs differ, the smaller aligned magnitude is subtracted from the larger. `res_sign` is the sign of the larger operand, and the addend's sign is used when the two are equal.
- R7: An exact-zero difference gives `res_zero`=1, `res_sig`=0 and `res_exp`=0. `res_sign` equals `round_down`, where 1 means rounding toward minus infinity.
- R8: A nonzero subtraction result is shifted left until bit 26 is 1, and the exponent is lowered by the number of places shifted. This happens in the same cycle.
- R9: While `in_valid` is low, the result outputs keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| prod_sign | input | 1 | Product sign |
| prod_exp | input | 10 | Product exponent, two's complement |
| prod_sig | input | 27 | Product significand with guard, round and sticky in bits 2:0 |
| add_sign | input | 1 | Addend sign |
| add_exp | input | 10 | Addend exponent, two's complement |
| add_sig | input | 24 | Addend significand, leading one at bit 23 |
| round_down | input | 1 | 1 when rounding toward minus infinity |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 10 | Result exponent, two's complement |
| res_sig | output | 27 | Unrounded result significand |
| res_zero | output | 1 | Exact-zero difference |

## Verification
Every result is due exactly one clock edge after the edge that sees `in_valid` high, because the only register between inputs and outputs is the output stage. The bench drives operands on a falling edge and lowers `in_valid` on the next falling edge. It samples all outputs at that same falling edge, which is half a cycle after the capturing edge. To check R1 and R9, it waits one more cycle with changed inputs. It then confirms that `out_valid` has dropped and that the result outputs have not moved. All expected significands and exponents are worked out by hand from the requirements.

// File: rtl/fma_align_pkg.sv
package fma_align_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

endpackage

// File: rtl/fma_sticky_rshift.sv
module fma_sticky_rshift #(
    parameter int W    = 27,
    parameter int SH_W = 11
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    localparam logic [SH_W-1:0] LIMIT = SH_W'(W);
    localparam logic [W-1:0]    ONE   = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] lost_mask;
    logic         lost;

    always_comb begin
        lost_mask = '0;
        lost      = 1'b0;
        if (amt >= LIMIT) begin
            // Everything leaves the window; only the sticky survives.
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            lost_mask = (ONE << amt) - ONE;
            lost      = |(din & lost_mask);
            dout      = (din >> amt) | {{(W-1){1'b0}}, lost};
        end
    end
endmodule

// File: rtl/fma_lead_zero.sv
module fma_lead_zero #(
    parameter int W    = 27,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     din,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = CNT_W'(W);
        // Ascending scan: the highest set bit is the last to write.
        for (int i = 0; i < W; i++) begin
            if (din[i]) cnt = CNT_W'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fma_align_norm.sv
module fma_align_norm
    import fma_align_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int GRS_W  = 3,
    parameter int EXP_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     prod_sign,
    input  logic signed [EXP_W-1:0]  prod_exp,
    input  logic [MANT_W+GRS_W-1:0]  prod_sig,
    input  logic                     add_sign,
    input  logic signed [EXP_W-1:0]  add_exp,
    input  logic [MANT_W-1:0]        add_sig,
    input  logic                     round_down,
    output logic                     out_valid,
    output logic                     res_sign,
    output logic signed [EXP_W-1:0]  res_exp,
    output logic [MANT_W+GRS_W-1:0]  res_sig,
    output logic                     res_zero
);
    localparam int SIG_W = MANT_W + GRS_W;
    localparam int SH_W  = EXP_W + 1;
    localparam int CNT_W = $clog2(SIG_W + 1);

    emit_state_t state_q, state_d;

    // Exponent comparison
    logic signed [SH_W-1:0] exp_gap;
    logic                   addend_dom;
    logic [SH_W-1:0]        sh_prod, sh_add;
    logic signed [EXP_W-1:0] base_exp;

    // Aligned operands
    logic [SIG_W-1:0] add_ext, prod_al, add_al;

    // Arithmetic
    logic [SIG_W:0]   mag_sum;
    logic [SIG_W-1:0] mag_diff, norm_sig;
    logic             add_ge;
    logic [CNT_W-1:0] lz;

    // Next result
    logic                    n_sign, n_zero;
    logic signed [EXP_W-1:0] n_exp;
    logic [SIG_W-1:0]        n_sig;

    assign add_ext    = {add_sig, {GRS_W{1'b0}}};
    assign exp_gap    = {add_exp[EXP_W-1], add_exp} - {prod_exp[EXP_W-1], prod_exp};
    assign addend_dom = exp_gap > 0;
    assign sh_prod    = addend_dom ? exp_gap : '0;
    assign sh_add     = addend_dom ? '0 : -exp_gap;
    assign base_exp   = addend_dom ? add_exp : prod_exp;

    fma_sticky_rshift #(.W(SIG_W), .SH_W(SH_W)) u_shift_prod (
        .din (prod_sig),
        .amt (sh_prod),
        .dout(prod_al)
    );

    fma_sticky_rshift #(.W(SIG_W), .SH_W(SH_W)) u_shift_add (
        .din (add_ext),
        .amt (sh_add),
        .dout(add_al)
    );

    assign mag_sum  = {1'b0, add_al} + {1'b0, prod_al};
    assign add_ge   = add_al >= prod_al;
    assign mag_diff = add_ge ? (add_al - prod_al) : (prod_al - add_al);

    fma_lead_zero #(.W(SIG_W), .CNT_W(CNT_W)) u_lz (
        .din(mag_diff),
        .cnt(lz)
    );

    assign norm_sig = mag_diff << lz;

    always_comb begin
        n_sign = add_sign;
        n_zero = 1'b0;
        n_exp  = base_exp;
        n_sig  = mag_sum[SIG_W-1:0];
        if (add_sign == prod_sign) begin
            if (mag_sum[SIG_W]) begin
                n_sig = mag_sum[SIG_W:1] | {{(SIG_W-1){1'b0}}, mag_sum[0]};
                n_exp = base_exp + EXP_W'(1);
            end
        end else if (mag_diff == '0) begin
            n_sign = round_down;
            n_zero = 1'b1;
            n_exp  = '0;
            n_sig  = '0;
        end else begin
            n_sign = add_ge ? add_sign : prod_sign;
            n_sig  = norm_sig;
            n_exp  = base_exp - $signed({{(EXP_W-CNT_W){1'b0}}, lz});
        end
    end

    // Controller: accept / drain
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign <= 1'b0;
            res_exp  <= '0;
            res_sig  <= '0;
            res_zero <= 1'b0;
        end else if (in_valid) begin
            res_sign <= n_sign;
            res_exp  <= n_exp;
            res_sig  <= n_sig;
            res_zero <= n_zero;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/fma_align_norm_chk.sv
module fma_align_norm_chk #(
    parameter int MANT_W = 24,
    parameter int GRS_W  = 3,
    parameter int EXP_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [MANT_W+GRS_W-1:0] prod_sig,
    input logic [MANT_W-1:0]       add_sig,
    input logic                    round_down,
    input logic                    out_valid,
    input logic                    res_sign,
    input logic [EXP_W-1:0]        res_exp,
    input logic [MANT_W+GRS_W-1:0] res_sig,
    input logic                    res_zero
);
    localparam int SIG_W = MANT_W + GRS_W;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zero_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_zero) |-> (res_sig == '0 && res_exp == '0));

    assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && res_zero == 1'b0) ##1 (out_valid && res_zero) |-> res_sign == $past(round_down));

    assert_lead_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prod_sig[SIG_W-1] && add_sig[MANT_W-1]) |=> (res_zero || res_sig[SIG_W-1]));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_sig) && $stable(res_exp) && $stable(res_sign) && $stable(res_zero)));
endmodule

bind fma_align_norm fma_align_norm_chk #(
    .MANT_W(MANT_W),
    .GRS_W (GRS_W),
    .EXP_W (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .prod_sig  (prod_sig),
    .add_sig   (add_sig),
    .round_down(round_down),
    .out_valid (out_valid),
    .res_sign  (res_sign),
    .res_exp   (res_exp),
    .res_sig   (res_sig),
    .res_zero  (res_zero)
);

// File: tb/fma_align_norm_bench.sv
module fma_align_norm_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               prod_sign = 1'b0;
    logic signed [9:0]  prod_exp = '0;
    logic [26:0]        prod_sig = '0;
    logic               add_sign = 1'b0;
    logic signed [9:0]  add_exp = '0;
    logic [23:0]        add_sig = '0;
    logic               round_down = 1'b0;
    logic               out_valid, res_sign, res_zero;
    logic signed [9:0]  res_exp;
    logic [26:0]        res_sig;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    fma_align_norm u_fma_align_norm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prod_sign(prod_sign), .prod_exp(prod_exp), .prod_sig(prod_sig),
        .add_sign(add_sign), .add_exp(add_exp), .add_sig(add_sig),
        .round_down(round_down), .out_valid(out_valid), .res_sign(res_sign),
        .res_exp(res_exp), .res_sig(res_sig), .res_zero(res_zero)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Drive one operand set, release in_valid, then compare the result.
    task automatic run_op(string tag, logic ps, int pe, logic [26:0] pm,
                          logic as, int ae, logic [23:0] am, logic rd,
                          logic xs, int xe, logic [26:0] xm, logic xz);
        @(negedge clk);
        prod_sign = ps; prod_exp = 10'(pe); prod_sig = pm;
        add_sign = as; add_exp = 10'(ae); add_sig = am;
        round_down = rd; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", longint'(out_valid), 1);
        check(tag, "res_sig", longint'(res_sig), longint'(xm));
        check(tag, "res_exp", longint'(int'(res_exp)), longint'(xe));
        check(tag, "res_sign", longint'(res_sign), longint'(xs));
        check(tag, "res_zero", longint'(res_zero), longint'(xz));
    endtask

    task automatic test_reset();
        check("R1", "reset out_valid", longint'(out_valid), 0);
        check("R1", "reset res_sig", longint'(res_sig), 0);
        check("R1", "reset res_exp", longint'(int'(res_exp)), 0);
        check("R1", "reset res_zero", longint'(res_zero), 0);
    endtask

    task automatic test_hold();
        logic [26:0] keep_sig = res_sig;
        int          keep_exp = int'(res_exp);
        @(negedge clk);
        prod_sig = 27'h5555555; add_sig = 24'hABCDEF; prod_exp = 10'sd100;
        add_sign = ~add_sign; round_down = ~round_down;
        @(negedge clk);
        check("R1", "out_valid after idle", longint'(out_valid), 0);
        check("R9", "held res_sig", longint'(res_sig), longint'(keep_sig));
        check("R9", "held res_exp", longint'(int'(res_exp)), longint'(keep_exp));
    endtask

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R2 R5: equal exponents, same sign, carry into bit 27
        run_op("R5", 0, 5, 27'h4000000, 0, 5, 24'h800000, 0, 0, 6, 27'h4000000, 0);
        // R5: carry with a one shifted out into the sticky
        run_op("R5", 0, 0, 27'h4000001, 0, 0, 24'h800000, 0, 0, 1, 27'h4000001, 0);
        // R2 R3: addend shifted right by 2, no carry, both negative
        run_op("R3", 1, 10, 27'h4000000, 1, 8, 24'h800000, 0, 1, 10, 27'h5000000, 0);
        // R3: product shifted by 3 with lost ones folded into bit 0
        run_op("R3", 0, 0, 27'h4000005, 0, 3, 24'h800000, 0, 0, 3, 27'h4800001, 0);
        // R4: shift of exactly 27 leaves only the sticky
        run_op("R4", 0, 0, 27'h4000000, 0, 27, 24'h800000, 0, 0, 27, 27'h4000001, 0);
        // R4 R8: shift of 40 then subtraction and one-place normalization
        run_op("R4", 0, 0, 27'h4000000, 1, 40, 24'h800000, 0, 1, 39, 27'h7FFFFFE, 0);
        // R6 R8: addend larger magnitude
        run_op("R6", 0, 5, 27'h4000000, 1, 5, 24'hC00000, 0, 1, 4, 27'h4000000, 0);
        // R6: product larger magnitude, product sign wins
        run_op("R6", 1, 5, 27'h7000000, 0, 5, 24'h800000, 0, 1, 4, 27'h6000000, 0);
        // R8: deep cancellation, 26-place shift
        run_op("R8", 0, 2, 27'h4000001, 1, 2, 24'h800000, 0, 0, -24, 27'h4000000, 0);
        // R7: exact zero, positive under nearest rounding
        run_op("R7", 0, 7, 27'h4000000, 1, 7, 24'h800000, 0, 0, 0, 27'h0, 1);
        // R7: exact zero, negative toward minus infinity
        run_op("R7", 1, 7, 27'h4000000, 0, 7, 24'h800000, 1, 1, 0, 27'h0, 1);
        // R9 R1: idle cycle keeps the last result
        run_op("R6", 0, 3, 27'h4000000, 1, 3, 24'hE00000, 0, 1, 2, 27'h6000000, 0);
        test_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule